// File: doc/BRIEF.md
# Cascaded 32-Bit Synchronous Counter Chain

This block is a wide synchronous binary up counter assembled from four identical 8-bit counter slices. No slice contains a carry adder across the full width. Instead, each slice raises an active-low "all ones" flag. A slice above the lowest one is allowed to advance only when the active-low OR of every lower slice's flag is low, which means every lower slice holds all ones. When that happens, the higher slice steps by one on the same rising edge on which the lower slices roll over to zero. On the next cycle their flags return high and the higher slice falls back to holding.

The chain can be loaded with a 32-bit preset on request. It can also run as a programmable divider. In reload mode, the flags of all slices are gated together into the load enables of every slice, so the chain reloads the preset only when the whole 32-bit value is all ones. Each slice's own reload-at-terminal feature is not used: the reload path lives outside the slices. The lowest slice's flag drives the enable of the second slice on its own wire, separate from the reload gating. The divide ratio is 2^32 minus the preset. The overall active-low terminal count marks the last state of each period.

Each slice chooses one of three named actions every cycle. LOAD is taken when its load enable is low, whatever its count enable. COUNT is taken when its load enable is high and its count enable is low. HOLD is taken when both enables are high. The slice moves between these actions freely from cycle to cycle as its enables change.

Top module: `wide_count_chain`

## Requirements
- R1: An active-high reset (`rst`), applied asynchronously, forces `count` to 0 and `tc_n` high, without waiting for a clock edge.
- R2: When `ld_n` is low at a rising edge, `count` takes the value of `preset` on that edge. This applies whatever the values of `cnt_en_n` and `reload_mode`.
- R3: When `ld_n` is high and `cnt_en_n` is low, and the count is not all ones, `count` increases by exactly one on each rising edge.
- R4: When `ld_n` and `cnt_en_n` are both high, `count` does not change. This holds even when the lower slices are all ones, for example 0x000000FF or 0x00FFFFFF.
- R5: Slice k, which holds bits [8k+7:8k], advances only on an enabled edge where all bits below 8k are one. A carry crosses every slice boundary within one edge, for example 0x00FFFFFF goes to 0x01000000.
- R6: `tc_n` is low exactly when all 32 bits of `count` are one, and high otherwise.
- R7: With `reload_mode` high, `cnt_en_n` low and `ld_n` high, a count of all ones is followed on the next edge by `preset` instead of 0. The period is therefore 2^32 − `preset` cycles, with `tc_n` low for one cycle in each period.
- R8: With `reload_mode` high, the chain counts normally while not at all ones. At all ones with `cnt_en_n` high, the count stays at all ones.
- R9: With `reload_mode` low, an enabled edge at all ones wraps `count` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high clear |
| cnt_en_n | input | 1 | Global count enable, active low |
| ld_n | input | 1 | Load request, active low |
| reload_mode | input | 1 | When high, reload `preset` at the all-ones state |
| preset | input | 32 | Value loaded into the chain |
| count | output | 32 | Current count |
| tc_n | output | 1 | Overall terminal count, low at all ones |

## Verification
The chain is compared every cycle against a 32-bit behavioural counter. Starting values are preloaded just below each slice boundary (0xFE, 0xFFFF, 0xFFFFFF and 0xFFFFFFFE), so a wrong carry gate shows up within a cycle or two as an upper byte that moves too early or fails to move. Hold patterns at 0xFF and 0xFFFFFF separate a correct enable path from one that ignores the global enable in the upper slices. A divide-by-13 run, together with a disabled all-ones state in reload mode, separates reload gating on the full width from reload on a partial width, and a wrap to 0 from a reload.

// File: rtl/cnt_chain_pkg.sv
package cnt_chain_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2
    } slice_act_e;
endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_chain_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce_n,
    input  logic         pe_n,
    input  logic [W-1:0] p,
    output logic [W-1:0] q,
    output logic         tc_n
);
    slice_act_e act;

    // action decode: load wins over count, count over hold
    always_comb begin
        unique case ({pe_n, ce_n})
            2'b00, 2'b01: act = ACT_LOAD;
            2'b10:        act = ACT_COUNT;
            2'b11:        act = ACT_HOLD;
            default:      act = ACT_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD:  q <= p;
                ACT_COUNT: q <= q + 1'b1;
                default:   q <= q;
            endcase
        end
    end

    // outputs
    always_comb begin
        tc_n = ~(&q);
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        !pe_n |=> q == $past(p));
    p_count_r3: assert property (@(posedge clk) disable iff (rst)
        (pe_n && !ce_n) |=> q == $past(q) + 1'b1);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (pe_n && ce_n) |=> $stable(q));
endmodule

// File: rtl/cnt_chain_gate.sv
module cnt_chain_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0] tc_n,
    input  logic         cnt_en_n,
    input  logic         ld_n,
    input  logic         reload_mode,
    output logic [N-1:0] ce_n,
    output logic [N-1:0] pe_n,
    output logic         all_tc_n
);
    // full-width terminal: OR of every active-low slice flag
    assign all_tc_n = |tc_n;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_gate
            if (k == 0) begin : g_low
                assign ce_n[k] = cnt_en_n;
            end else begin : g_up
                // separate path from the reload gating; global enable folded in
                assign ce_n[k] = cnt_en_n | (|tc_n[k-1:0]);
            end
            assign pe_n[k] = ld_n & (cnt_en_n | ~reload_mode | all_tc_n);
        end
    endgenerate
endmodule

// File: rtl/wide_count_chain.sv
module wide_count_chain #(
    parameter int SLICE_W  = 8,
    parameter int N_SLICES = 4,
    parameter int TOTAL_W  = SLICE_W * N_SLICES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_en_n,
    input  logic               ld_n,
    input  logic               reload_mode,
    input  logic [TOTAL_W-1:0] preset,
    output logic [TOTAL_W-1:0] count,
    output logic               tc_n
);
    localparam logic [TOTAL_W-1:0] ALL_ONES = {TOTAL_W{1'b1}};

    logic [N_SLICES-1:0] sl_tc_n;
    logic [N_SLICES-1:0] sl_ce_n;
    logic [N_SLICES-1:0] sl_pe_n;
    logic                all_tc_n;

    cnt_chain_gate #(.N(N_SLICES)) u_gate (
        .tc_n        (sl_tc_n),
        .cnt_en_n    (cnt_en_n),
        .ld_n        (ld_n),
        .reload_mode (reload_mode),
        .ce_n        (sl_ce_n),
        .pe_n        (sl_pe_n),
        .all_tc_n    (all_tc_n)
    );

    genvar k;
    generate
        for (k = 0; k < N_SLICES; k++) begin : g_slice
            cnt_slice #(.W(SLICE_W)) u_slice (
                .clk  (clk),
                .rst  (rst),
                .ce_n (sl_ce_n[k]),
                .pe_n (sl_pe_n[k]),
                .p    (preset[k*SLICE_W +: SLICE_W]),
                .q    (count[k*SLICE_W +: SLICE_W]),
                .tc_n (sl_tc_n[k])
            );
            if (k > 0) begin : g_chk
                p_carry_r5: assert property (@(posedge clk) disable iff (rst)
                    (ld_n && count[k*SLICE_W-1:0] != {(k*SLICE_W){1'b1}})
                    |=> count[k*SLICE_W +: SLICE_W] == $past(count[k*SLICE_W +: SLICE_W]));
            end
        end
    endgenerate

    assign tc_n = all_tc_n;

    p_tc_r6: assert property (@(posedge clk) disable iff (rst)
        (count == ALL_ONES) == !tc_n);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ld_n && cnt_en_n) |=> $stable(count));
    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_n && !cnt_en_n && reload_mode && count == ALL_ONES) |=> count == $past(preset));
    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (ld_n && !cnt_en_n && !reload_mode && count == ALL_ONES) |=> count == '0);
endmodule

// File: tb/wide_count_chain_bench.sv
module wide_count_chain_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en_n = 1'b1;
    logic        ld_n = 1'b1;
    logic        reload_mode = 1'b0;
    logic [31:0] preset = '0;
    logic [31:0] count;
    logic        tc_n;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [31:0] exp_cnt = '0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    wide_count_chain u_wide_count_chain (
        .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .ld_n(ld_n),
        .reload_mode(reload_mode), .preset(preset), .count(count), .tc_n(tc_n)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one clock: predict, wait through the edge, compare at the negedge
    task automatic step(input string req);
        if (!ld_n) exp_cnt = preset;
        else if (!cnt_en_n) begin
            if (exp_cnt == 32'hFFFF_FFFF && reload_mode) exp_cnt = preset;
            else exp_cnt = exp_cnt + 32'd1;
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, count, exp_cnt);
        chk({req, " tc_n"}, {31'd0, tc_n}, {31'd0, (exp_cnt != 32'hFFFF_FFFF)});
    endtask

    task automatic load(input logic [31:0] v, input string req);
        preset = v; ld_n = 1'b0;
        step(req);
        ld_n = 1'b1;
    endtask

    task automatic t_reset_r1;
        #12;
        chk("R1 reset count", count, 32'd0);
        chk("R1 reset tc_n", {31'd0, tc_n}, 32'd1);
        @(negedge clk); rst = 1'b0;
        load(32'hFFFF_FFFF, "R2 load before async clear");
        #2 rst = 1'b1; #1;
        chk("R1 async clear", count, 32'd0);
        chk("R1 async tc_n", {31'd0, tc_n}, 32'd1);
        @(negedge clk); rst = 1'b0; exp_cnt = '0;
    endtask

    task automatic t_load_r2;
        cnt_en_n = 1'b1; reload_mode = 1'b0;
        load(32'h1234_5678, "R2 load idle");
        load(32'hFFFF_FFFF, "R2 load all ones");
        cnt_en_n = 1'b0; reload_mode = 1'b1;
        load(32'h0BAD_F00D, "R2 load beats reload and count");
        cnt_en_n = 1'b1; reload_mode = 1'b0;
    endtask

    task automatic t_count_r3;
        load(32'h1234_5678, "R3 setup");
        cnt_en_n = 1'b0;
        for (int i = 0; i < 5; i++) step("R3 count a");
        cnt_en_n = 1'b1;
        load(32'hA5A5_A5A0, "R3 setup");
        cnt_en_n = 1'b0;
        for (int i = 0; i < 4; i++) step("R3 count b");
        cnt_en_n = 1'b1;
    endtask

    task automatic t_hold_r4;
        load(32'h0000_00FF, "R4 setup");
        for (int i = 0; i < 3; i++) step("R4 hold at FF");
        load(32'h00FF_FFFF, "R4 setup");
        for (int i = 0; i < 3; i++) step("R4 hold at FFFFFF");
    endtask

    task automatic t_carry_r5;
        load(32'h0000_00FE, "R5 setup");
        cnt_en_n = 1'b0;
        for (int i = 0; i < 3; i++) step("R5 carry byte0");
        cnt_en_n = 1'b1;
        load(32'h0000_FFFF, "R5 setup");
        cnt_en_n = 1'b0; step("R5 carry byte1"); cnt_en_n = 1'b1;
        chk("R5 16-bit boundary", count, 32'h0001_0000);
        load(32'h00FF_FFFF, "R5 setup");
        cnt_en_n = 1'b0; step("R5 carry byte2"); cnt_en_n = 1'b1;
        chk("R5 24-bit boundary", count, 32'h0100_0000);
        load(32'h12FF_FEFF, "R5 setup");
        cnt_en_n = 1'b0;
        for (int i = 0; i < 2; i++) step("R5 partial ones");
        cnt_en_n = 1'b1;
    endtask

    task automatic t_tc_wrap_r6_r9;
        reload_mode = 1'b0;
        load(32'h7FFF_FFFF, "R6 top bit clear");
        load(32'hFFFF_FFFE, "R6 one below");
        cnt_en_n = 1'b0;
        step("R6 reach all ones");
        chk("R6 tc_n low", {31'd0, tc_n}, 32'd0);
        step("R9 wrap to zero");
        chk("R9 wrapped", count, 32'd0);
        cnt_en_n = 1'b1;
    endtask

    task automatic t_reload_r7;
        int lows = 0;
        reload_mode = 1'b1;
        load(32'hFFFF_FFF3, "R7 setup");
        cnt_en_n = 1'b0;
        for (int i = 0; i < 26; i++) begin
            step("R7 divide by 13");
            if (!tc_n) lows++;
        end
        cnt_en_n = 1'b1;
        chk("R7 terminal pulses in 26 cycles", lows, 32'd2);
        chk("R7 phase after 2 periods", count, 32'hFFFF_FFF3);
    endtask

    task automatic t_mode_r8;
        reload_mode = 1'b1;
        load(32'h0000_1234, "R8 setup");
        cnt_en_n = 1'b0;
        for (int i = 0; i < 3; i++) step("R8 normal count in reload mode");
        cnt_en_n = 1'b1;
        load(32'hFFFF_FFFF, "R8 setup");
        preset = 32'h5555_5555;
        for (int i = 0; i < 2; i++) step("R8 disabled at all ones");
        chk("R8 still all ones", count, 32'hFFFF_FFFF);
        reload_mode = 1'b0;
    endtask

    initial begin
        t_reset_r1();
        t_load_r2();
        t_count_r3();
        t_hold_r4();
        t_carry_r5();
        t_tc_wrap_r6_r9();
        t_reload_r7();
        t_mode_r8();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule